// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-facing register file of a two-channel UART. A host drives a 3-bit register address, two active-low channel selects, a read strobe, a write strobe and a data byte. Each channel keeps its own configuration registers. The block decides which register an access reaches from that channel's current line control value, its two divisor bytes and one feature control bit.

Writing the line control register moves a channel between three overlaid banks: standard, divisor and enhanced. Some addresses reach one register on a read and a different one on a write. Serializer, FIFO and interrupt logic sit outside this block. The block shows their status bytes on reads. For accesses those neighbours must act on, it gives them registered one-cycle pulses together with the written byte.

Top module: `uart_bank_regfile`

## Requirements
- R1: An access reaches channel A only when cs_a_n is low and cs_b_n is high, and channel B only in the opposite case. With both selects low, the access changes no register and raises no pulse. rdata is 0x00 unless exactly one select is low.
- R2: Address 3 is the line control register. It can be read and written in every bank. The channel is in the enhanced bank when line control equals 0xBF. It is in the divisor bank when bit 7 is 1 and the value is not 0xBF. Otherwise it is in the standard bank.
- R3: In the standard bank, a read of address 0 returns the channel's rhr_in byte and raises its rhr_rd pulse. A write to address 0 raises thr_wr. Address 1 is a read/write interrupt enable register.
- R4: In the divisor bank, addresses 0 and 1 are the read/write low and high divisor bytes.
- R5: In the divisor bank, while both divisor bytes are 0x00, reads of address 0 return DEV_REV (default 0x01) and reads of address 1 return DEV_ID (default 0x0A).
- R6: Outside the enhanced bank, a read of address 2 returns isr_in and a write to address 2 raises fcr_wr.
- R7: Outside the enhanced bank, address 4 is a read/write modem control register. A read of address 5 returns lsr_in and a read of address 6 returns msr_in. Writes to addresses 5 and 6 change no register and raise no pulse.
- R8: Outside the enhanced bank, address 7 depends on feature control bit 6. When the bit is 0, address 7 is a read/write scratch byte. When it is 1, a read returns lvl_in and raises lvl_rd, and a write raises emsr_wr.
- R9: In the enhanced bank, a read of address 0 returns lvl_in and raises lvl_rd, and a write to address 0 raises trg_wr. Address 1 is feature control and address 2 is the enhanced function byte. Addresses 4, 5, 6 and 7 are flow characters on, on-alternate, off and off-alternate. All of these are read/write.
- R10: After asynchronous reset, every register and every pulse output is 0, so each channel starts in the standard bank.
- R11: Every pulse is high for exactly the one cycle after the clock edge that samples its strobe. At most one write pulse is high at a time. wr_byte carries the written byte while a write pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_a_n | input | 1 | Channel A select, active low |
| cs_b_n | input | 1 | Channel B select, active low |
| addr | input | 3 | Register address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rhr_in | input | 16 | Receive byte per channel, A in bits 7:0 |
| isr_in | input | 16 | Interrupt status per channel |
| lsr_in | input | 16 | Line status per channel |
| msr_in | input | 16 | Modem status per channel |
| lvl_in | input | 16 | FIFO level count per channel |
| rdata | output | 8 | Read data, combinational |
| thr_wr | output | 2 | Transmit byte write pulse per channel |
| fcr_wr | output | 2 | FIFO control write pulse per channel |
| trg_wr | output | 2 | Trigger level write pulse per channel |
| emsr_wr | output | 2 | Enhanced mode write pulse per channel |
| rhr_rd | output | 2 | Receive byte read pulse per channel |
| lvl_rd | output | 2 | FIFO level read pulse per channel |
| wr_byte | output | 8 | Byte of the last write, valid with a write pulse |

## Verification
The address map is tried in each bank, and on every entry to and exit from the 0xBF value. A read at one address can then only match the model if the bank was decoded correctly. The divisor bytes are set to zero, to a nonzero low byte and back to zero. This separates the identification readback from a plain divisor read. Accesses with both selects low, with no select, and on channel B are each checked against channel A's untouched state, which catches crossed or leaking channel gating. A long random run, weighted toward the bank-switching byte values, then mixes reads and writes. It compares every readback and every pulse with a reference model of the register state.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      BANK_STD,
      BANK_DIV,
      BANK_ENH
   } bank_e;

   typedef enum logic [4:0] {
      RS_ZERO, RS_RHR, RS_IER, RS_DLL, RS_DLM, RS_REV, RS_ID,
      RS_ISR, RS_LCR, RS_MCR, RS_LSR, RS_MSR, RS_SPR, RS_LVL,
      RS_FCTR, RS_EFR, RS_XON1, RS_XON2, RS_XOFF1, RS_XOFF2
   } rd_sel_e;

   typedef enum logic [4:0] {
      WS_NONE, WS_THR, WS_IER, WS_DLL, WS_DLM, WS_FCR, WS_LCR,
      WS_MCR, WS_SPR, WS_EMSR, WS_TRG, WS_FCTR, WS_EFR,
      WS_XON1, WS_XON2, WS_XOFF1, WS_XOFF2
   } wr_sel_e;

   typedef struct packed {
      logic [BYTE_W-1:0] lcr;
      logic [BYTE_W-1:0] ier;
      logic [BYTE_W-1:0] dll;
      logic [BYTE_W-1:0] dlm;
      logic [BYTE_W-1:0] mcr;
      logic [BYTE_W-1:0] spr;
      logic [BYTE_W-1:0] fctr;
      logic [BYTE_W-1:0] efr;
      logic [BYTE_W-1:0] xon1;
      logic [BYTE_W-1:0] xon2;
      logic [BYTE_W-1:0] xoff1;
      logic [BYTE_W-1:0] xoff2;
   } chan_regs_t;

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
   import uart_bank_pkg::*;
#(
   parameter logic [7:0] ENH_KEY   = 8'hBF,
   parameter int         ADDR_W    = 3,
   parameter int         ALT_BIT   = 6
) (
   input  logic [7:0]        lcr,
   input  logic              div_zero,
   input  logic [7:0]        fctr,
   input  logic [ADDR_W-1:0] addr,
   output bank_e             bank,
   output rd_sel_e           rsel,
   output wr_sel_e           wsel
);

   logic alt_map;
   assign alt_map = fctr[ALT_BIT];

   always_comb begin
      if (lcr == ENH_KEY)  bank = BANK_ENH;
      else if (lcr[7])     bank = BANK_DIV;
      else                 bank = BANK_STD;
   end

   always_comb begin
      rsel = RS_ZERO;
      wsel = WS_NONE;
      unique case (addr)
         3'd0: begin
            unique case (bank)
               BANK_STD: begin rsel = RS_RHR; wsel = WS_THR; end
               BANK_DIV: begin rsel = div_zero ? RS_REV : RS_DLL; wsel = WS_DLL; end
               default:  begin rsel = RS_LVL; wsel = WS_TRG; end
            endcase
         end
         3'd1: begin
            unique case (bank)
               BANK_STD: begin rsel = RS_IER;  wsel = WS_IER; end
               BANK_DIV: begin rsel = div_zero ? RS_ID : RS_DLM; wsel = WS_DLM; end
               default:  begin rsel = RS_FCTR; wsel = WS_FCTR; end
            endcase
         end
         3'd2: begin
            if (bank == BANK_ENH) begin rsel = RS_EFR; wsel = WS_EFR; end
            else                  begin rsel = RS_ISR; wsel = WS_FCR; end
         end
         3'd3: begin
            rsel = RS_LCR; wsel = WS_LCR;
         end
         3'd4: begin
            if (bank == BANK_ENH) begin rsel = RS_XON1; wsel = WS_XON1; end
            else                  begin rsel = RS_MCR;  wsel = WS_MCR;  end
         end
         3'd5: begin
            if (bank == BANK_ENH) begin rsel = RS_XON2; wsel = WS_XON2; end
            else                  begin rsel = RS_LSR;  wsel = WS_NONE; end
         end
         3'd6: begin
            if (bank == BANK_ENH) begin rsel = RS_XOFF1; wsel = WS_XOFF1; end
            else                  begin rsel = RS_MSR;   wsel = WS_NONE;  end
         end
         default: begin
            if (bank == BANK_ENH) begin rsel = RS_XOFF2; wsel = WS_XOFF2; end
            else if (alt_map)     begin rsel = RS_LVL;   wsel = WS_EMSR;  end
            else                  begin rsel = RS_SPR;   wsel = WS_SPR;   end
         end
      endcase
   end

   // R2
   always_comb begin
      bank_key_chk: assert ((bank != BANK_ENH) || (lcr == ENH_KEY));
   end

endmodule

// File: rtl/uart_bank_chan.sv
module uart_bank_chan
   import uart_bank_pkg::*;
#(
   parameter logic [7:0] ENH_KEY = 8'hBF,
   parameter logic [7:0] DEV_REV = 8'h01,
   parameter logic [7:0] DEV_ID  = 8'h0A,
   parameter int         ADDR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [7:0]        rhr_in,
   input  logic [7:0]        isr_in,
   input  logic [7:0]        lsr_in,
   input  logic [7:0]        msr_in,
   input  logic [7:0]        lvl_in,
   output logic [7:0]        rdata,
   output logic              thr_wr,
   output logic              fcr_wr,
   output logic              trg_wr,
   output logic              emsr_wr,
   output logic              rhr_rd,
   output logic              lvl_rd
);

   chan_regs_t regs;
   bank_e      bank;
   rd_sel_e    rsel;
   wr_sel_e    wsel;
   logic       wr_en;
   logic       rd_en;
   logic       div_zero;

   assign wr_en    = sel && wr_stb;
   assign rd_en    = sel && rd_stb;
   assign div_zero = (regs.dll == '0) && (regs.dlm == '0);

   uart_bank_decode #(
      .ENH_KEY (ENH_KEY),
      .ADDR_W  (ADDR_W),
      .ALT_BIT (6)
   ) u_decode (
      .lcr      (regs.lcr),
      .div_zero (div_zero),
      .fctr     (regs.fctr),
      .addr     (addr),
      .bank     (bank),
      .rsel     (rsel),
      .wsel     (wsel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '0;
      end else if (wr_en) begin
         unique case (wsel)
            WS_IER:   regs.ier   <= wdata;
            WS_DLL:   regs.dll   <= wdata;
            WS_DLM:   regs.dlm   <= wdata;
            WS_LCR:   regs.lcr   <= wdata;
            WS_MCR:   regs.mcr   <= wdata;
            WS_SPR:   regs.spr   <= wdata;
            WS_FCTR:  regs.fctr  <= wdata;
            WS_EFR:   regs.efr   <= wdata;
            WS_XON1:  regs.xon1  <= wdata;
            WS_XON2:  regs.xon2  <= wdata;
            WS_XOFF1: regs.xoff1 <= wdata;
            WS_XOFF2: regs.xoff2 <= wdata;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_wr  <= 1'b0;
         fcr_wr  <= 1'b0;
         trg_wr  <= 1'b0;
         emsr_wr <= 1'b0;
         rhr_rd  <= 1'b0;
         lvl_rd  <= 1'b0;
      end else begin
         thr_wr  <= wr_en && (wsel == WS_THR);
         fcr_wr  <= wr_en && (wsel == WS_FCR);
         trg_wr  <= wr_en && (wsel == WS_TRG);
         emsr_wr <= wr_en && (wsel == WS_EMSR);
         rhr_rd  <= rd_en && (rsel == RS_RHR);
         lvl_rd  <= rd_en && (rsel == RS_LVL);
      end
   end

   always_comb begin
      unique case (rsel)
         RS_RHR:   rdata = rhr_in;
         RS_IER:   rdata = regs.ier;
         RS_DLL:   rdata = regs.dll;
         RS_DLM:   rdata = regs.dlm;
         RS_REV:   rdata = DEV_REV;
         RS_ID:    rdata = DEV_ID;
         RS_ISR:   rdata = isr_in;
         RS_LCR:   rdata = regs.lcr;
         RS_MCR:   rdata = regs.mcr;
         RS_LSR:   rdata = lsr_in;
         RS_MSR:   rdata = msr_in;
         RS_SPR:   rdata = regs.spr;
         RS_LVL:   rdata = lvl_in;
         RS_FCTR:  rdata = regs.fctr;
         RS_EFR:   rdata = regs.efr;
         RS_XON1:  rdata = regs.xon1;
         RS_XON2:  rdata = regs.xon2;
         RS_XOFF1: rdata = regs.xoff1;
         RS_XOFF2: rdata = regs.xoff2;
         default:  rdata = '0;
      endcase
   end

   // R2
   lcr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr == 3'd3)) |=> (regs.lcr == $past(wdata)));

   // R7
   ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (regs.lcr != ENH_KEY) && ((addr == 3'd5) || (addr == 3'd6)))
      |=> ($stable(regs) && !thr_wr && !fcr_wr && !trg_wr && !emsr_wr));

   // R11
   wr_pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({thr_wr, fcr_wr, trg_wr, emsr_wr}));

   // R11
   wr_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr || fcr_wr || trg_wr || emsr_wr) |-> $past(wr_en));

   // R3
   rhr_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rhr_rd || lvl_rd) |-> $past(rd_en));

   // R5
   id_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && regs.lcr[7] && (regs.lcr != ENH_KEY) && (addr == 3'd1) && div_zero)
      |-> (rdata == DEV_ID));

endmodule

// File: rtl/uart_bank_regfile.sv
module uart_bank_regfile
   import uart_bank_pkg::*;
#(
   parameter int         DATA_W  = 8,
   parameter int         ADDR_W  = 3,
   parameter logic [7:0] ENH_KEY = 8'hBF,
   parameter logic [7:0] DEV_REV = 8'h01,
   parameter logic [7:0] DEV_ID  = 8'h0A
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_a_n,
   input  logic                     cs_b_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     rd_stb,
   input  logic                     wr_stb,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [2*DATA_W-1:0]      rhr_in,
   input  logic [2*DATA_W-1:0]      isr_in,
   input  logic [2*DATA_W-1:0]      lsr_in,
   input  logic [2*DATA_W-1:0]      msr_in,
   input  logic [2*DATA_W-1:0]      lvl_in,
   output logic [DATA_W-1:0]        rdata,
   output logic [1:0]               thr_wr,
   output logic [1:0]               fcr_wr,
   output logic [1:0]               trg_wr,
   output logic [1:0]               emsr_wr,
   output logic [1:0]               rhr_rd,
   output logic [1:0]               lvl_rd,
   output logic [DATA_W-1:0]        wr_byte
);

   localparam int NUM_CH = 2;

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("uart_bank_regfile: DATA_W must be 8");
   end
   if (ADDR_W != 3) begin : g_bad_addr
      $error("uart_bank_regfile: ADDR_W must be 3");
   end

   logic [NUM_CH-1:0]        chan_sel;
   logic [DATA_W-1:0]        ch_rdata [NUM_CH];
   logic [DATA_W-1:0]        rd_mux;

   assign chan_sel[0] = !cs_a_n &&  cs_b_n;
   assign chan_sel[1] =  cs_a_n && !cs_b_n;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      uart_bank_chan #(
         .ENH_KEY (ENH_KEY),
         .DEV_REV (DEV_REV),
         .DEV_ID  (DEV_ID),
         .ADDR_W  (ADDR_W)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (chan_sel[ch]),
         .rd_stb  (rd_stb),
         .wr_stb  (wr_stb),
         .addr    (addr),
         .wdata   (wdata),
         .rhr_in  (rhr_in[ch*DATA_W +: DATA_W]),
         .isr_in  (isr_in[ch*DATA_W +: DATA_W]),
         .lsr_in  (lsr_in[ch*DATA_W +: DATA_W]),
         .msr_in  (msr_in[ch*DATA_W +: DATA_W]),
         .lvl_in  (lvl_in[ch*DATA_W +: DATA_W]),
         .rdata   (ch_rdata[ch]),
         .thr_wr  (thr_wr[ch]),
         .fcr_wr  (fcr_wr[ch]),
         .trg_wr  (trg_wr[ch]),
         .emsr_wr (emsr_wr[ch]),
         .rhr_rd  (rhr_rd[ch]),
         .lvl_rd  (lvl_rd[ch])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (chan_sel[ch]) rd_mux = rd_mux | ch_rdata[ch];
      end
   end
   assign rdata = rd_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    wr_byte <= '0;
      else if (wr_stb && |chan_sel)  wr_byte <= wdata;
   end

   // R1
   dual_cs_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_a_n && !cs_b_n) |=> ((thr_wr | fcr_wr | trg_wr | emsr_wr | rhr_rd | lvl_rd) == '0));

   // R1
   dual_cs_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_a_n && !cs_b_n) |-> (rdata == '0));

endmodule

// File: tb/uart_bank_regfile_bench.sv
module uart_bank_regfile_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] REV = 8'h01;
   localparam logic [7:0] DID = 8'h0A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_a_n = 1'b1;
   logic        cs_b_n = 1'b1;
   logic [2:0]  addr = '0;
   logic        rd_stb = 1'b0;
   logic        wr_stb = 1'b0;
   logic [7:0]  wdata = '0;
   logic [15:0] rhr_in = '0, isr_in = '0, lsr_in = '0, msr_in = '0, lvl_in = '0;
   logic [7:0]  rdata;
   logic [1:0]  thr_wr, fcr_wr, trg_wr, emsr_wr, rhr_rd, lvl_rd;
   logic [7:0]  wr_byte;

   int checks = 0;
   int failures = 0;

   logic [7:0] m_lcr[2], m_ier[2], m_dll[2], m_dlm[2], m_mcr[2], m_spr[2];
   logic [7:0] m_fctr[2], m_efr[2], m_xon1[2], m_xon2[2], m_xoff1[2], m_xoff2[2];

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_bank_regfile u_uart_bank_regfile (
      .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .addr(addr),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rhr_in(rhr_in),
      .isr_in(isr_in), .lsr_in(lsr_in), .msr_in(msr_in), .lvl_in(lvl_in),
      .rdata(rdata), .thr_wr(thr_wr), .fcr_wr(fcr_wr), .trg_wr(trg_wr),
      .emsr_wr(emsr_wr), .rhr_rd(rhr_rd), .lvl_rd(lvl_rd), .wr_byte(wr_byte)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   function automatic int bank_of(input int ch);
      if (m_lcr[ch] == 8'hBF) return 2;
      if (m_lcr[ch][7])       return 1;
      return 0;
   endfunction

   function automatic string req_of(input int ch, input logic [2:0] a);
      int b = bank_of(ch);
      if (a == 3'd3) return "R2";
      if (b == 2) return "R9";
      case (a)
         3'd0, 3'd1: return (b == 1) ? "R4/R5" : "R3";
         3'd2: return "R6";
         3'd7: return "R8";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [7:0] exp_rd(input int ch, input logic [2:0] a);
      int b = bank_of(ch);
      logic z = (m_dll[ch] == 8'h00) && (m_dlm[ch] == 8'h00);
      if (a == 3'd3) return m_lcr[ch];
      if (b == 2) begin
         case (a)
            3'd0: return lvl_in[ch*8 +: 8];
            3'd1: return m_fctr[ch];
            3'd2: return m_efr[ch];
            3'd4: return m_xon1[ch];
            3'd5: return m_xon2[ch];
            3'd6: return m_xoff1[ch];
            default: return m_xoff2[ch];
         endcase
      end
      case (a)
         3'd0: return (b == 0) ? rhr_in[ch*8 +: 8] : (z ? REV : m_dll[ch]);
         3'd1: return (b == 0) ? m_ier[ch] : (z ? DID : m_dlm[ch]);
         3'd2: return isr_in[ch*8 +: 8];
         3'd4: return m_mcr[ch];
         3'd5: return lsr_in[ch*8 +: 8];
         3'd6: return msr_in[ch*8 +: 8];
         default: return m_fctr[ch][6] ? lvl_in[ch*8 +: 8] : m_spr[ch];
      endcase
   endfunction

   // read pulse kind: 0 none, 1 receive byte, 2 level
   function automatic int rd_kind(input int ch, input logic [2:0] a);
      int b = bank_of(ch);
      if (a == 3'd0 && b == 0) return 1;
      if (a == 3'd0 && b == 2) return 2;
      if (a == 3'd7 && b != 2 && m_fctr[ch][6]) return 2;
      return 0;
   endfunction

   // write pulse kind: 0 none, 1 thr, 2 fcr, 3 trg, 4 emsr; updates the model
   function automatic int model_write(input int ch, input logic [2:0] a, input logic [7:0] d);
      int b = bank_of(ch);
      if (a == 3'd3) begin m_lcr[ch] = d; return 0; end
      if (b == 2) begin
         case (a)
            3'd0: return 3;
            3'd1: m_fctr[ch] = d;
            3'd2: m_efr[ch] = d;
            3'd4: m_xon1[ch] = d;
            3'd5: m_xon2[ch] = d;
            3'd6: m_xoff1[ch] = d;
            default: m_xoff2[ch] = d;
         endcase
         return 0;
      end
      case (a)
         3'd0: if (b == 0) return 1; else m_dll[ch] = d;
         3'd1: if (b == 0) m_ier[ch] = d; else m_dlm[ch] = d;
         3'd2: return 2;
         3'd4: m_mcr[ch] = d;
         3'd7: if (m_fctr[ch][6]) return 4; else m_spr[ch] = d;
         default: ;
      endcase
      return 0;
   endfunction

   task automatic model_reset();
      for (int ch = 0; ch < 2; ch++) begin
         m_lcr[ch] = 0; m_ier[ch] = 0; m_dll[ch] = 0; m_dlm[ch] = 0;
         m_mcr[ch] = 0; m_spr[ch] = 0; m_fctr[ch] = 0; m_efr[ch] = 0;
         m_xon1[ch] = 0; m_xon2[ch] = 0; m_xoff1[ch] = 0; m_xoff2[ch] = 0;
      end
   endtask

   task automatic drive_status();
      rhr_in = 16'($urandom); isr_in = 16'($urandom); lsr_in = 16'($urandom);
      msr_in = 16'($urandom); lvl_in = 16'($urandom);
   endtask

   // csel: 0 = A, 1 = B, 2 = none, 3 = both
   task automatic do_write(input int csel, input logic [2:0] a, input logic [7:0] d);
      int kind = 0;
      string req;
      logic [1:0] e_thr, e_fcr, e_trg, e_emsr;
      @(negedge clk);
      drive_status();
      cs_a_n = !(csel == 0 || csel == 3);
      cs_b_n = !(csel == 1 || csel == 3);
      addr = a; wdata = d; wr_stb = 1'b1;
      req = (csel < 2) ? req_of(csel, a) : "R1";
      if (csel < 2) kind = model_write(csel, a, d);
      e_thr = '0; e_fcr = '0; e_trg = '0; e_emsr = '0;
      if (csel < 2) begin
         e_thr[csel]  = (kind == 1);
         e_fcr[csel]  = (kind == 2);
         e_trg[csel]  = (kind == 3);
         e_emsr[csel] = (kind == 4);
      end
      @(negedge clk);
      wr_stb = 1'b0; cs_a_n = 1'b1; cs_b_n = 1'b1;
      check({thr_wr, fcr_wr, trg_wr, emsr_wr} == {e_thr, e_fcr, e_trg, e_emsr},
            {req, " R11"}, "write pulses", {thr_wr, fcr_wr, trg_wr, emsr_wr},
            {e_thr, e_fcr, e_trg, e_emsr});
      if (kind != 0) check(wr_byte == d, "R11", "wr_byte", wr_byte, d);
   endtask

   task automatic do_read(input int csel, input logic [2:0] a);
      logic [7:0] exp = 8'h00;
      int kind = 0;
      logic [1:0] e_rhr, e_lvl;
      string req;
      @(negedge clk);
      drive_status();
      cs_a_n = !(csel == 0 || csel == 3);
      cs_b_n = !(csel == 1 || csel == 3);
      addr = a; rd_stb = 1'b1;
      req = (csel < 2) ? req_of(csel, a) : "R1";
      if (csel < 2) begin
         exp = exp_rd(csel, a);
         kind = rd_kind(csel, a);
      end
      e_rhr = '0; e_lvl = '0;
      if (csel < 2) begin
         e_rhr[csel] = (kind == 1);
         e_lvl[csel] = (kind == 2);
      end
      #2;
      check(rdata == exp, req, "rdata", rdata, exp);
      @(negedge clk);
      rd_stb = 1'b0; cs_a_n = 1'b1; cs_b_n = 1'b1;
      check({rhr_rd, lvl_rd} == {e_rhr, e_lvl}, {req, " R11"}, "read pulses",
            {4'h0, rhr_rd, lvl_rd}, {4'h0, e_rhr, e_lvl});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      check({thr_wr, fcr_wr, trg_wr, emsr_wr} == 8'h00, "R10", "pulses after reset",
            {thr_wr, fcr_wr, trg_wr, emsr_wr}, 8'h00);
      check(wr_byte == 8'h00, "R10", "wr_byte after reset", wr_byte, 8'h00);
      do_read(0, 3'd3);
      do_read(1, 3'd1);
      do_read(2, 3'd3);
      // R3 standard bank
      do_write(0, 3'd1, 8'h5A);
      do_read(0, 3'd1);
      do_read(0, 3'd0);
      do_write(0, 3'd0, 8'h33);
      @(negedge clk);
      check(thr_wr == 2'b00, "R11", "thr pulse one cycle", {6'h0, thr_wr}, 8'h00);
      // R6, R7
      do_write(0, 3'd2, 8'hC1);
      do_read(0, 3'd2);
      do_write(0, 3'd4, 8'h1F);
      do_write(0, 3'd5, 8'hEE);
      do_write(0, 3'd6, 8'hDD);
      do_read(0, 3'd4);
      do_read(0, 3'd5);
      do_read(0, 3'd6);
      do_read(0, 3'd1);
      // R2, R4, R5 divisor bank
      do_write(0, 3'd3, 8'h80);
      do_read(0, 3'd3);
      do_read(0, 3'd0);
      do_read(0, 3'd1);
      do_write(0, 3'd0, 8'h12);
      do_read(0, 3'd0);
      do_read(0, 3'd1);
      do_write(0, 3'd0, 8'h00);
      do_read(0, 3'd0);
      do_write(0, 3'd1, 8'h04);
      do_read(0, 3'd1);
      do_read(0, 3'd0);
      // R9 enhanced bank
      do_write(0, 3'd3, 8'hBF);
      do_read(0, 3'd3);
      do_write(0, 3'd1, 8'h40);
      do_write(0, 3'd2, 8'h10);
      for (int a = 4; a < 8; a++) do_write(0, 3'(a), 8'(8'h60 + a));
      for (int a = 0; a < 8; a++) do_read(0, 3'(a));
      do_write(0, 3'd0, 8'h2C);
      // R8 alternate address 7
      do_write(0, 3'd3, 8'h03);
      do_read(0, 3'd7);
      do_write(0, 3'd7, 8'h77);
      do_read(0, 3'd1);
      do_write(0, 3'd3, 8'hBF);
      do_write(0, 3'd1, 8'h00);
      do_write(0, 3'd3, 8'h00);
      do_write(0, 3'd7, 8'hA5);
      do_read(0, 3'd7);
      do_read(0, 3'd0);
      // R1 select gating
      do_write(3, 3'd1, 8'hFF);
      do_read(3, 3'd1);
      do_read(0, 3'd1);
      do_write(1, 3'd1, 8'h3C);
      do_read(1, 3'd1);
      do_read(0, 3'd1);
      do_write(2, 3'd4, 8'h99);
      do_read(0, 3'd4);
      // random mix
      for (int i = 0; i < 1500; i++) begin
         int r = int'($urandom_range(0, 9));
         int csel = (r < 4) ? 0 : (r < 8) ? 1 : (r == 8) ? 2 : 3;
         logic [2:0] a = 3'($urandom);
         logic [7:0] d = 8'($urandom);
         case ($urandom_range(0, 7))
            0: d = 8'hBF;
            1: d = 8'h80;
            2: d = 8'h00;
            3: d = 8'h40;
            default: ;
         endcase
         if ($urandom_range(0, 9) < 6) do_read(csel, a);
         else                          do_write(csel, a, d);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule